// File: doc/BRIEF.md
# Adapter Option Register Bank and Host Memory Window Decoder

This block holds the configuration of a legacy expansion-bus network adapter and decodes the host memory window the adapter occupies. It has eight consecutive I/O ports at a base set by board switches. Two of those ports return a fixed, read-only card identifier. The others hold the card-enable flag, a flag that switches the boot EPROM off, the placement of the memory window, and a code that selects the interrupt line.

The window is 16 KB in size and sits on a 16 KB boundary chosen by host address bits A19..A14. When the card is enabled and a host memory address falls inside the window, the decoder raises exactly one select line. The possible regions are the shared RAM, the byte-wide station-address PROM, the 16-bit data register, the status/control port and the command port. Reserved and unused addresses raise none of these lines.

A two-state machine tracks whether the card is enabled. In state CARD_OFF, the transition ENABLE is taken on a write to the control port with bit 0 set. In state CARD_ON, the transition DISABLE is taken on a write to the control port with bit 0 clear. Every other cycle keeps the current state (HOLD). Register writes take effect at the rising clock edge. The I/O read data and the memory selects are combinational from the current address and the stored configuration.

Top module: `optsel_top`

## Requirements
- R1: After reset the card is disabled, the EPROM-off flag is 0, the window base is 0 and the interrupt code is 0. Offsets 2, 3 and 4 read back 0x00, boot_rom_en is 1 and irq_line is 3.
- R2: Offset 0 reads 0xFD and offset 1 reads 0x6A. Writes to either offset leave these values unchanged.
- R3: Offset 2 holds card enable in bit 0 (1 = on) and EPROM off in bit 1 (1 = off). It reads back as {6'b0, bit1, bit0}, and boot_rom_en equals the inverse of bit 1.
- R4: Offset 3 stores write-data bits 5..0 as host address bits A19..A14 of the window base. It reads back as {2'b0, base}.
- R5: Offset 4 stores write-data bits 1..0 as the interrupt code, and reads back as {6'b0, code}. irq_line is 3, 5, 9 or 11 for codes 0, 1, 2 and 3.
- R6: The bank is selected when io_addr[9:3] equals io_base_sw. Offsets 5 to 7, and any address outside the bank, read 0xFF. Writes to them change no readable register and no output.
- R7: While card enable is 0, no memory select is asserted.
- R8: With the card enabled and mem_addr[19:14] equal to the base, window offsets 0x0000 to 0x3FBF assert sel_ram.
- R9: Even window offsets 0x3FC0 to 0x3FDE assert sel_prom. Odd offsets in that range assert no select.
- R10: Window offsets 0x3FF0 to 0x3FF1 assert sel_data, 0x3FF2 asserts sel_stat and 0x3FF3 asserts sel_cmd.
- R11: Window offsets 0x3FE0 to 0x3FEF and 0x3FF4 to 0x3FFF, and every address outside the window, assert no select. At most one select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 10 | Host I/O address |
| io_base_sw | input | 7 | Switch-set bank base, compared with io_addr[9:3] |
| io_wr | input | 1 | I/O write strobe, sampled at the rising edge |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for io_addr |
| mem_addr | input | 20 | Host memory address |
| sel_ram | output | 1 | Shared RAM selected |
| sel_prom | output | 1 | Address PROM selected (even bytes only) |
| sel_data | output | 1 | Data register selected |
| sel_stat | output | 1 | Status/control port selected |
| sel_cmd | output | 1 | Command port selected |
| boot_rom_en | output | 1 | Boot EPROM enabled |
| irq_line | output | 4 | Selected interrupt line number |

## Verification
On every cycle, the checker confirms the following. The selects are one-hot or idle, and none is raised while the card is off. A RAM select only occurs with the upper address bits equal to the stored base, and a PROM select only occurs on an even address. The unused ports read 0xFF. Writes to the enable and base ports land in the next cycle.

The bench covers what those properties cannot show. It sweeps every offset of the window for several bases and compares the exact region boundaries. It writes every interrupt code and every control value and checks the readback. It confirms that the ID ports, the unused ports and writes aimed at a different bank base change nothing.

// File: rtl/optsel_pkg.sv
`timescale 1ns/1ps
package optsel_pkg;

    typedef enum logic [0:0] {
        CARD_OFF = 1'b0,
        CARD_ON  = 1'b1
    } card_state_e;

    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_RAM  = 3'd1,
        RGN_PROM = 3'd2,
        RGN_DATA = 3'd3,
        RGN_STAT = 3'd4,
        RGN_CMD  = 3'd5
    } region_e;

    localparam int NUM_SEL = 5;

    localparam logic [2:0] OFS_ID_LO = 3'd0;
    localparam logic [2:0] OFS_ID_HI = 3'd1;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_BASE  = 3'd3;
    localparam logic [2:0] OFS_IRQ   = 3'd4;

    localparam logic [7:0] RD_IDLE = 8'hFF;

endpackage

// File: rtl/optsel_regs.sv
`timescale 1ns/1ps
module optsel_regs
    import optsel_pkg::*;
#(
    parameter int         IO_AW  = 10,
    parameter int         BASE_W = 6,
    parameter logic [7:0] ID_LO  = 8'hFD,
    parameter logic [7:0] ID_HI  = 8'h6A
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IO_AW-1:0]       io_addr,
    input  logic [IO_AW-4:0]       io_base_sw,
    input  logic                   io_wr,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    output logic                   card_en,
    output logic                   boot_rom_en,
    output logic [BASE_W-1:0]      win_base,
    output logic [3:0]             irq_line
);

    localparam int PORT_BITS = 3;

    card_state_e         state_q, state_d;
    logic                eprom_off_q;
    logic [BASE_W-1:0]   base_q;
    logic [1:0]          irq_code_q;
    logic                bank_hit;
    logic [2:0]          ofs;
    logic                wr_ctrl, wr_base, wr_irq;

    assign bank_hit = (io_addr[IO_AW-1:PORT_BITS] == io_base_sw);
    assign ofs      = io_addr[PORT_BITS-1:0];
    assign wr_ctrl  = io_wr && bank_hit && (ofs == OFS_CTRL);
    assign wr_base  = io_wr && bank_hit && (ofs == OFS_BASE);
    assign wr_irq   = io_wr && bank_hit && (ofs == OFS_IRQ);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CARD_OFF;
        else        state_q <= state_d;
    end

    // transitions: ENABLE, DISABLE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CARD_OFF: if (wr_ctrl && io_wdata[0])  state_d = CARD_ON;
            CARD_ON:  if (wr_ctrl && !io_wdata[0]) state_d = CARD_OFF;
            default:  state_d = CARD_OFF;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        card_en = 1'b0;
        unique case (state_q)
            CARD_OFF: card_en = 1'b0;
            CARD_ON:  card_en = 1'b1;
            default:  card_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eprom_off_q <= 1'b0;
            base_q      <= '0;
            irq_code_q  <= 2'd0;
        end else begin
            if (wr_ctrl) eprom_off_q <= io_wdata[1];
            if (wr_base) base_q      <= io_wdata[BASE_W-1:0];
            if (wr_irq)  irq_code_q  <= io_wdata[1:0];
        end
    end

    assign boot_rom_en = ~eprom_off_q;
    assign win_base    = base_q;

    always_comb begin
        unique case (irq_code_q)
            2'd0: irq_line = 4'd3;
            2'd1: irq_line = 4'd5;
            2'd2: irq_line = 4'd9;
            2'd3: irq_line = 4'd11;
            default: irq_line = 4'd3;
        endcase
    end

    always_comb begin
        io_rdata = RD_IDLE;
        if (bank_hit) begin
            unique case (ofs)
                OFS_ID_LO: io_rdata = ID_LO;
                OFS_ID_HI: io_rdata = ID_HI;
                OFS_CTRL:  io_rdata = {6'b0, eprom_off_q, card_en};
                OFS_BASE:  io_rdata = {{(8-BASE_W){1'b0}}, base_q};
                OFS_IRQ:   io_rdata = {6'b0, irq_code_q};
                default:   io_rdata = RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/optsel_decode.sv
`timescale 1ns/1ps
module optsel_decode
    import optsel_pkg::*;
#(
    parameter int MEM_AW    = 20,
    parameter int WIN_AW    = 14,
    parameter int RAM_BYTES = 16320,
    parameter int PROM_BYTES = 32,
    parameter int RSV_BYTES = 16,
    localparam int BASE_W   = MEM_AW - WIN_AW
) (
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [BASE_W-1:0] win_base,
    input  logic              card_en,
    output logic [NUM_SEL-1:0] sel_vec
);

    localparam logic [WIN_AW-1:0] PROM_LO = WIN_AW'(RAM_BYTES);
    localparam logic [WIN_AW-1:0] PROM_HI = WIN_AW'(RAM_BYTES + PROM_BYTES);
    localparam logic [WIN_AW-1:0] DATA_LO = WIN_AW'(RAM_BYTES + PROM_BYTES + RSV_BYTES);
    localparam logic [WIN_AW-1:0] DATA_HI = WIN_AW'(RAM_BYTES + PROM_BYTES + RSV_BYTES + 1);
    localparam logic [WIN_AW-1:0] STAT_AD = WIN_AW'(RAM_BYTES + PROM_BYTES + RSV_BYTES + 2);
    localparam logic [WIN_AW-1:0] CMD_AD  = WIN_AW'(RAM_BYTES + PROM_BYTES + RSV_BYTES + 3);

    logic              win_hit;
    logic [WIN_AW-1:0] wofs;
    region_e           rgn;

    assign win_hit = card_en && (mem_addr[MEM_AW-1:WIN_AW] == win_base);
    assign wofs    = mem_addr[WIN_AW-1:0];

    always_comb begin
        rgn = RGN_NONE;
        if (win_hit) begin
            if (wofs < PROM_LO)                         rgn = RGN_RAM;
            else if (wofs < PROM_HI && !wofs[0])        rgn = RGN_PROM;
            else if (wofs == DATA_LO || wofs == DATA_HI) rgn = RGN_DATA;
            else if (wofs == STAT_AD)                   rgn = RGN_STAT;
            else if (wofs == CMD_AD)                    rgn = RGN_CMD;
        end
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_vec[g] = (rgn == region_e'(g + 1));
    end

endmodule

// File: rtl/optsel_top.sv
`timescale 1ns/1ps
module optsel_top
    import optsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  io_addr,
    input  logic [6:0]  io_base_sw,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic [19:0] mem_addr,
    output logic        sel_ram,
    output logic        sel_prom,
    output logic        sel_data,
    output logic        sel_stat,
    output logic        sel_cmd,
    output logic        boot_rom_en,
    output logic [3:0]  irq_line
);

    localparam int IO_AW  = 10;
    localparam int MEM_AW = 20;
    localparam int WIN_AW = 14;
    localparam int BASE_W = MEM_AW - WIN_AW;

    logic              card_en;
    logic [BASE_W-1:0] win_base;
    logic [NUM_SEL-1:0] sel_vec;

    optsel_regs #(.IO_AW(IO_AW), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_base_sw(io_base_sw),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .card_en(card_en), .boot_rom_en(boot_rom_en),
        .win_base(win_base), .irq_line(irq_line)
    );

    optsel_decode #(.MEM_AW(MEM_AW), .WIN_AW(WIN_AW)) u_dec (
        .mem_addr(mem_addr), .win_base(win_base), .card_en(card_en),
        .sel_vec(sel_vec)
    );

    assign sel_ram  = sel_vec[0];
    assign sel_prom = sel_vec[1];
    assign sel_data = sel_vec[2];
    assign sel_stat = sel_vec[3];
    assign sel_cmd  = sel_vec[4];

endmodule

// File: rtl/optsel_chk.sv
`timescale 1ns/1ps
module optsel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [9:0]  io_addr,
    input logic [6:0]  io_base_sw,
    input logic        io_wr,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic [19:0] mem_addr,
    input logic        sel_ram,
    input logic        sel_prom,
    input logic        sel_data,
    input logic        sel_stat,
    input logic        sel_cmd,
    input logic        card_en,
    input logic [5:0]  win_base
);

    logic in_bank;
    assign in_bank = (io_addr[9:3] == io_base_sw);

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_prom, sel_data, sel_stat, sel_cmd}));

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !card_en |-> !(sel_ram || sel_prom || sel_data || sel_stat || sel_cmd));

    p_ram_in_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ram |-> (mem_addr[19:14] == win_base));

    p_prom_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_prom |-> !mem_addr[0]);

    p_unused_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_bank || io_addr[2:0] > 3'd4) |-> io_rdata == 8'hFF);

    p_enable_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && in_bank && io_addr[2:0] == 3'd2) |=> card_en == $past(io_wdata[0]));

    p_base_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && in_bank && io_addr[2:0] == 3'd3) |=> win_base == $past(io_wdata[5:0]));

    p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && in_bank && io_addr[2:0] == 3'd3) |=> $stable(win_base));

endmodule

bind optsel_top optsel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_base_sw(io_base_sw),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mem_addr(mem_addr), .sel_ram(sel_ram), .sel_prom(sel_prom),
    .sel_data(sel_data), .sel_stat(sel_stat), .sel_cmd(sel_cmd),
    .card_en(card_en), .win_base(win_base)
);

// File: tb/sim_optsel_top.sv
`timescale 1ns/1ps
module sim_optsel_top;

    localparam logic [6:0] SW = 7'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  io_addr = '0;
    logic [6:0]  io_base_sw = SW;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr = '0;
    logic        sel_ram, sel_prom, sel_data, sel_stat, sel_cmd;
    logic        boot_rom_en;
    logic [3:0]  irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    optsel_top u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_base_sw(io_base_sw),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_addr(mem_addr), .sel_ram(sel_ram), .sel_prom(sel_prom),
        .sel_data(sel_data), .sel_stat(sel_stat), .sel_cmd(sel_cmd),
        .boot_rom_en(boot_rom_en), .irq_line(irq_line)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [6:0] blk, input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        io_addr = {blk, ofs}; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        #1;
    endtask

    task automatic io_read(input logic [6:0] blk, input logic [2:0] ofs, output logic [7:0] d);
        io_addr = {blk, ofs};
        #1;
        d = io_rdata;
    endtask

    function automatic logic [4:0] exp_sel(input int o);
        if (o < 16320)                        return 5'b00001;
        if (o < 16352 && (o % 2) == 0)        return 5'b00010;
        if (o == 16368 || o == 16369)         return 5'b00100;
        if (o == 16370)                       return 5'b01000;
        if (o == 16371)                       return 5'b10000;
        return 5'b00000;
    endfunction

    function automatic string sel_tag(input int o);
        if (o < 16320) return "R8";
        if (o < 16352) return "R9";
        if (o >= 16368 && o <= 16371) return "R10";
        return "R11";
    endfunction

    function automatic logic [3:0] exp_irq(input int c);
        return (c < 2) ? 4'(3 + 2 * c) : 4'(9 + 2 * (c - 2));
    endfunction

    logic [4:0] selv;
    assign selv = {sel_cmd, sel_stat, sel_data, sel_prom, sel_ram};

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        io_read(SW, 3'd2, rd); chk("R1", rd, 8'h00);
        io_read(SW, 3'd3, rd); chk("R1", rd, 8'h00);
        io_read(SW, 3'd4, rd); chk("R1", rd, 8'h00);
        chk("R1", boot_rom_en, 1);
        chk("R1", irq_line, 3);
        mem_addr = 20'h00000; #1; chk("R7", selv, 0);

        // R2 identifier
        io_read(SW, 3'd0, rd); chk("R2", rd, 8'hFD);
        io_read(SW, 3'd1, rd); chk("R2", rd, 8'h6A);
        io_write(SW, 3'd0, 8'h00); io_write(SW, 3'd1, 8'h11);
        io_read(SW, 3'd0, rd); chk("R2", rd, 8'hFD);
        io_read(SW, 3'd1, rd); chk("R2", rd, 8'h6A);

        // R6 unused ports and other bank bases
        for (int o = 5; o < 8; o++) begin
            io_write(SW, 3'(o), 8'h5A);
            io_read(SW, 3'(o), rd); chk("R6", rd, 8'hFF);
        end
        io_write(SW ^ 7'h01, 3'd2, 8'h03);
        io_write(SW ^ 7'h10, 3'd3, 8'h2A);
        io_read(SW, 3'd2, rd); chk("R6", rd, 8'h00);
        io_read(SW, 3'd3, rd); chk("R6", rd, 8'h00);
        chk("R6", boot_rom_en, 1);
        for (int o = 0; o < 8; o++) begin
            io_read(SW ^ 7'h01, 3'(o), rd); chk("R6", rd, 8'hFF);
        end

        // R5 interrupt code
        for (int c = 0; c < 4; c++) begin
            io_write(SW, 3'd4, 8'(8'hFC | c));
            io_read(SW, 3'd4, rd); chk("R5", rd, 8'(c));
            chk("R5", irq_line, exp_irq(c));
        end

        // R3 control bits
        for (int v = 0; v < 4; v++) begin
            io_write(SW, 3'd2, 8'(8'hF0 | v));
            io_read(SW, 3'd2, rd); chk("R3", rd, 8'(v));
            chk("R3", boot_rom_en, ((v >> 1) & 1) == 0);
        end
        io_write(SW, 3'd2, 8'h00);

        // R7 no selects while disabled
        for (int o = 0; o < 16384; o += 97) begin
            mem_addr = 20'(o); #1; chk("R7", selv, 0);
        end

        // R4, R8-R11 window sweeps
        for (int k = 0; k < 4; k++) begin
            int b;
            b = (k == 0) ? 0 : (k == 1) ? 6'h15 : (k == 2) ? 6'h2A : 6'h3F;
            io_write(SW, 3'd3, 8'(8'hC0 | b));
            io_read(SW, 3'd3, rd); chk("R4", rd, 8'(b));
            io_write(SW, 3'd2, 8'h01);
            for (int o = 0; o < 16384; o++) begin
                mem_addr = {6'(b), 14'(o)}; #1;
                chk(sel_tag(o), selv, exp_sel(o));
            end
            for (int o = 0; o < 16384; o += 211) begin
                mem_addr = {6'(b) ^ 6'h01, 14'(o)}; #1; chk("R11", selv, 0);
                mem_addr = {6'(b) ^ 6'h20, 14'(o)}; #1; chk("R11", selv, 0);
            end
        end

        // R7 disable again and confirm the window goes quiet
        io_write(SW, 3'd2, 8'h00);
        for (int o = 16300; o < 16384; o++) begin
            mem_addr = {6'h3F, 14'(o)}; #1; chk("R7", selv, 0);
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule